// File: doc/BRIEF.md
# CVSD Delta Modulation Decoder

This block rebuilds a signed linear sample stream from a serial continuously variable slope delta bit stream. Each time the decoder data clock enable is high, it takes one received bit. It checks whether the newest three or four bits are all the same value. It then adapts a step size through a syllabic integrator and moves a leaky principal integrator up or down by that step. The arithmetic is the same as in the matching encoder. With equal parameters and reset state, the decoder output therefore equals the encoder's running estimate after every bit.

Two controls change what the decoder does. An active-low force-idle input replaces the received bits with an internal alternating pattern, which drives the output toward zero. An active-low powersave input freezes all state and forces the output to zero. Lowpass reconstruction filtering and any analog stage are outside this block.

Top module: `cvsd_dec`

## Requirements
- R1: After reset, `sample_o` is 0 and `valid_o` is 0. The step size equals `STEP_MIN`. The bit history holds an alternating pattern, so no run is detected.
- R2: `valid_o` is high for exactly the one clock after each cycle in which `bit_en_i` and `pwr_on_i` are both high. It is low in every other cycle.
- R3: The run flag is computed with the new bit shifted into the history. With `alg3_i` = 1 the flag is set when the 3 newest bits are equal. With `alg3_i` = 0 it is set when the 4 newest bits are equal.
- R4: On each decoded bit the step size is updated. If the run flag is set, step becomes min(step + `STEP_INC`, `STEP_MAX`). Otherwise step becomes max(step - (step >> `DECAY_SH`), `STEP_MIN`).
- R5: On each decoded bit the integrator is updated using the new step. acc becomes acc - (acc >>> `LEAK_SH`) + step when the bit is 1, and acc - (acc >>> `LEAK_SH`) - step when the bit is 0. The result is clamped to ±(2^(W-1)-1). `sample_o` shows acc one clock after the bit.
- R6: In a cycle where `bit_en_i` is low, `bit_i` has no effect, and `sample_o` keeps its value.
- R7: While `idle_ni` is 0, `bit_i` is ignored. The decoded bits are 0,1,0,1,… and the first bit after `idle_ni` falls is 0.
- R8: After 512 forced-idle bits, starting from any state, |`sample_o`| ≤ `STEP_MIN`.
- R9: While `pwr_on_i` is 0, `sample_o` is 0, `valid_o` stays low and no state changes. Once `pwr_on_i` returns to 1, the held integrator value shows on `sample_o` again and decoding continues from the held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_en_i | input | 1 | Data clock enable; one received bit is taken per high cycle |
| bit_i | input | 1 | Received serial bit |
| alg3_i | input | 1 | 1 selects 3-bit run detection, 0 selects 4-bit run detection |
| idle_ni | input | 1 | Active-low force-idle |
| pwr_on_i | input | 1 | Active-low powersave (0 = quiescent) |
| sample_o | output | W | Reconstructed signed sample |
| valid_o | output | 1 | One-cycle strobe after each decoded bit |

## Verification
The bench drives long runs of one value so that the step climbs to `STEP_MAX` and the integrator reaches both clamps. A design with a wrong clamp or an overflowing sum would wrap in sign at that point.

It feeds three-bit runs under both algorithm settings. A decoder that picked the wrong run length would grow its step where it should decay, and the sample would drift away from the model.

Forced idle is entered from a saturated state and held for 512 bits. This exposes a wrong first idle bit, a stuck phase, or a missing leak, any of which keeps the output away from zero. Powersave is toggled around clocked bits: leaked updates or a lost held value would show up as a wrong sample after the decoder wakes.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;
  localparam int unsigned HIST_W = 4;
  localparam logic [HIST_W-1:0] HIST_RST = 4'b0101;

  function automatic int clamp_sym(input int v, input int lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction
endpackage

// File: rtl/cvsd_run_det.sv
module cvsd_run_det
  import cvsd_pkg::*;
#(
  parameter int unsigned SHORT_RUN = 3,
  parameter int unsigned LONG_RUN  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic bit_i,
  input  logic alg3_i,
  output logic coinc_o
);
  localparam int unsigned HW = (LONG_RUN > SHORT_RUN) ? LONG_RUN : SHORT_RUN;

  logic [HW-1:0] hist_q, hist_nxt;
  logic [HW:1]   same;

  assign hist_nxt = {hist_q[HW-2:0], bit_i};

  // same[k]: newest k bits equal
  for (genvar k = 1; k <= HW; k++) begin : g_same
    assign same[k] = (&hist_nxt[k-1:0]) | ~(|hist_nxt[k-1:0]);
  end

  assign coinc_o = alg3_i ? same[SHORT_RUN] : same[LONG_RUN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hist_q <= HW'(HIST_RST);
    else if (adv_i) hist_q <= hist_nxt;
  end
endmodule

// File: rtl/cvsd_syllabic.sv
module cvsd_syllabic #(
  parameter int unsigned STEP_W   = 16,
  parameter int unsigned STEP_MIN = 16,
  parameter int unsigned STEP_MAX = 2048,
  parameter int unsigned STEP_INC = 64,
  parameter int unsigned DECAY_SH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              coinc_i,
  output logic [STEP_W-1:0] step_nxt_o,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W:0] MAX_X = (STEP_W+1)'(STEP_MAX);
  localparam logic [STEP_W:0] MIN_X = (STEP_W+1)'(STEP_MIN);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W:0]   grow, shrink;

  always_comb begin
    grow   = {1'b0, step_q} + (STEP_W+1)'(STEP_INC);
    shrink = {1'b0, step_q} - {1'b0, (step_q >> DECAY_SH)};
    if (coinc_i) step_nxt_o = (grow > MAX_X)   ? STEP_W'(STEP_MAX) : grow[STEP_W-1:0];
    else         step_nxt_o = (shrink < MIN_X) ? STEP_W'(STEP_MIN) : shrink[STEP_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    step_q <= STEP_W'(STEP_MIN);
    else if (adv_i) step_q <= step_nxt_o;
  end

  assign step_o = step_q;

  assert_step_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q >= STEP_W'(STEP_MIN)) && (step_q <= STEP_W'(STEP_MAX)));

  assert_run_grows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && coinc_i) |=> (step_q >= $past(step_q)));
endmodule

// File: rtl/cvsd_principal.sv
module cvsd_principal #(
  parameter int unsigned W       = 16,
  parameter int unsigned STEP_W  = 16,
  parameter int unsigned LEAK_SH = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                adv_i,
  input  logic                bit_i,
  input  logic [STEP_W-1:0]   step_i,
  output logic signed [W-1:0] acc_o
);
  localparam int XW = (W > STEP_W ? W : STEP_W) + 3;
  localparam logic signed [XW-1:0] LIM =  XW'((2 ** (W-1)) - 1);

  logic signed [W-1:0]  acc_q;
  logic signed [XW-1:0] ext, stp, sum, acc_nxt;

  always_comb begin
    ext = XW'(acc_q);
    stp = $signed({{(XW-STEP_W){1'b0}}, step_i});
    sum = ext - (ext >>> LEAK_SH) + (bit_i ? stp : -stp);
    if (sum > LIM)       acc_nxt = LIM;
    else if (sum < -LIM) acc_nxt = -LIM;
    else                 acc_nxt = sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (adv_i) acc_q <= acc_nxt[W-1:0];
  end

  assign acc_o = acc_q;

  assert_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q != {1'b1, {(W-1){1'b0}}});

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(acc_q));
endmodule

// File: rtl/cvsd_dec.sv
module cvsd_dec #(
  parameter int unsigned W        = 16,
  parameter int unsigned STEP_MIN = 16,
  parameter int unsigned STEP_MAX = 2048,
  parameter int unsigned STEP_INC = 64,
  parameter int unsigned DECAY_SH = 4,
  parameter int unsigned LEAK_SH  = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_en_i,
  input  logic                bit_i,
  input  logic                alg3_i,
  input  logic                idle_ni,
  input  logic                pwr_on_i,
  output logic signed [W-1:0] sample_o,
  output logic                valid_o
);
  localparam int unsigned STEP_W = W;

  logic adv, dbit, phase_q, coinc, valid_q;
  logic [STEP_W-1:0] step_nxt, step_cur;
  logic signed [W-1:0] acc;

  assign adv  = bit_en_i & pwr_on_i;
  assign dbit = idle_ni ? bit_i : phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= 1'b0;
    else if (idle_ni) phase_q <= 1'b0;
    else if (adv)     phase_q <= ~phase_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= adv;
  end

  cvsd_run_det #(.SHORT_RUN(3), .LONG_RUN(4)) u_run (
    .clk_i, .rst_ni, .adv_i(adv), .bit_i(dbit), .alg3_i, .coinc_o(coinc)
  );

  cvsd_syllabic #(
    .STEP_W(STEP_W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX),
    .STEP_INC(STEP_INC), .DECAY_SH(DECAY_SH)
  ) u_syl (
    .clk_i, .rst_ni, .adv_i(adv), .coinc_i(coinc),
    .step_nxt_o(step_nxt), .step_o(step_cur)
  );

  cvsd_principal #(.W(W), .STEP_W(STEP_W), .LEAK_SH(LEAK_SH)) u_pri (
    .clk_i, .rst_ni, .adv_i(adv), .bit_i(dbit), .step_i(step_nxt), .acc_o(acc)
  );

  assign sample_o = pwr_on_i ? acc : '0;
  assign valid_o  = valid_q;

  assert_valid_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bit_en_i && pwr_on_i));

  assert_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_on_i |=> ($stable(acc) && $stable(step_cur) && !valid_o));

  assert_idle_alt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_ni && adv && $past(!idle_ni && adv)) |-> (dbit != $past(dbit)));
endmodule

// File: tb/sim_cvsd_dec.sv
module sim_cvsd_dec;
  import cvsd_pkg::*;
  localparam int CLK_P = 10;
  localparam int W = 16, SMIN = 16, SMAX = 2048, SINC = 64, DSH = 4, LSH = 5;
  localparam int LIM = (2 ** (W-1)) - 1;

  logic clk = 0, rst_n = 0;
  logic bit_en = 0, bit_d = 0, alg3 = 1, idle_n = 1, pwr_on = 1;
  logic signed [W-1:0] sample;
  logic valid;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_acc = 0, m_step = SMIN, m_phase = 0;
  logic [3:0] m_hist = 4'b0101;

  always #(CLK_P/2) clk = ~clk;

  cvsd_dec #(.W(W), .STEP_MIN(SMIN), .STEP_MAX(SMAX), .STEP_INC(SINC),
             .DECAY_SH(DSH), .LEAK_SH(LSH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .bit_i(bit_d), .alg3_i(alg3),
    .idle_ni(idle_n), .pwr_on_i(pwr_on), .sample_o(sample), .valid_o(valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_bit(input int b);
    int used, t;
    bit run;
    if (!idle_n) begin used = m_phase; m_phase ^= 1; end
    else begin used = b; m_phase = 0; end
    m_hist = {m_hist[2:0], used[0]};
    run = alg3 ? (m_hist[2:0] == 3'b000 || m_hist[2:0] == 3'b111)
               : (m_hist == 4'h0 || m_hist == 4'hF);
    if (run) m_step = (m_step + SINC > SMAX) ? SMAX : m_step + SINC;
    else     m_step = (m_step - (m_step >> DSH) < SMIN) ? SMIN : m_step - (m_step >> DSH);
    t = m_acc - (m_acc >>> LSH) + (used != 0 ? m_step : -m_step);
    m_acc = clamp_sym(t, LIM);
  endfunction

  task automatic set_idle(input logic v);
    @(negedge clk);
    idle_n = v;
    if (v) m_phase = 0;
  endtask

  task automatic send_bit(input int b, input string req);
    @(negedge clk);
    bit_d = b[0];
    bit_en = 1;
    if (pwr_on) model_bit(b);
    @(negedge clk);
    bit_en = 0;
    bit_d = $urandom_range(0, 1);
    chk({req, " sample"}, int'(sample), pwr_on ? m_acc : 0);
    chk("R2 strobe high", int'(valid), int'(pwr_on));
    @(negedge clk);
    chk("R2 strobe low", int'(valid), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int keep;
    void'($urandom(32'd1234));
    #(CLK_P * 3);
    @(negedge clk);
    chk("R1 reset sample", int'(sample), 0);
    chk("R1 reset valid", int'(valid), 0);
    rst_n = 1;
    // step starts at min, no spurious run: alternating bits leave step at STEP_MIN
    send_bit(1, "R1 first bit");
    send_bit(0, "R1 second bit");

    // R3 directed: 3-run with alg3=1 grows, with alg3=0 does not
    alg3 = 1;
    for (int i = 0; i < 3; i++) send_bit(1, "R3 three-run alg3=1");
    alg3 = 0;
    for (int i = 0; i < 3; i++) send_bit(0, "R3 three-run alg3=0");
    send_bit(0, "R3 four-run alg3=0");

    // R4/R5 random with both algorithms, biased runs
    for (int i = 0; i < 400; i++) begin
      if (i % 50 == 0) alg3 = $urandom_range(0, 1);
      send_bit(($urandom_range(0, 3) != 0) ? (i / 7) % 2 : $urandom_range(0, 1), "R4 R5 random");
    end

    // R5 saturation both ends
    for (int i = 0; i < 90; i++) send_bit(1, "R5 climb");
    chk("R5 upper clamp", int'(sample), LIM);
    for (int i = 0; i < 120; i++) send_bit(0, "R5 fall");
    chk("R5 lower clamp", int'(sample), -LIM);

    // R6: bit toggling without enable
    keep = int'(sample);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); bit_d = ~bit_d;
      @(negedge clk);
      chk("R6 no enable hold", int'(sample), keep);
      chk("R6 no strobe", int'(valid), 0);
    end

    // R7/R8 forced idle from saturated state, random serial input ignored
    set_idle(0);
    for (int i = 0; i < 512; i++) send_bit($urandom_range(0, 1), "R7 forced idle");
    chk("R8 idle settle", (sample < 0 ? -int'(sample) : int'(sample)) <= SMIN, 1);
    set_idle(1);
    set_idle(0);
    send_bit(1, "R7 first idle bit is 0");
    set_idle(1);

    // R9 powersave
    for (int i = 0; i < 20; i++) send_bit(1, "R9 pre");
    keep = m_acc;
    @(negedge clk); pwr_on = 0;
    @(negedge clk);
    chk("R9 output zero", int'(sample), 0);
    for (int i = 0; i < 5; i++) send_bit(0, "R9 frozen");
    @(negedge clk); pwr_on = 1;
    @(negedge clk);
    chk("R9 held value", int'(sample), keep);
    for (int i = 0; i < 30; i++) send_bit($urandom_range(0, 1), "R9 resume");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule